// File: doc/BRIEF.md
# Load/Store Alignment and Extension Stage

This block is the data-side access stage of a 32-bit byte-addressed core. For every request it forms the effective address from a base register value and a sign-extended immediate displacement. It checks that address against the access width and drives a simple synchronous memory port with a word address, byte enables and store data. For a load, it returns the fetched bytes to the register file write port, sign-extended or zero-extended as selected.

An access whose address is not aligned to its width is turned into an alignment exception. The faulting effective address is reported so that it can be captured into an exception address register. A faulting access reaches neither memory nor the register file.

Memory reads are synchronous. The request cycle drives the memory port combinationally, and the load result, the register write and any exception appear on the cycle after the request. The memory side is big-endian: address offset 0 within a word is the most significant byte.

Top module: `lsu_align_ext`

## Requirements
- R1: The effective address (EA) is `req_base` plus `req_disp` sign-extended to 32 bits. `mem_addr` carries EA bits 31:2 in the request cycle.
- R2: A word access (`req_size` 2'b10, and the spare code 2'b11, which is also treated as a word) whose EA has either of bits 1:0 set raises an alignment exception.
- R3: A half-word access (`req_size` 2'b01) whose EA has bit 0 set raises an alignment exception. A half-word at offset 2 is legal.
- R4: A byte access (`req_size` 2'b00) never raises an alignment exception, at any offset.
- R5: A faulting access keeps `mem_en` low and all `mem_be` bits low in the request cycle, so a faulting store leaves memory unchanged. `mem_be` is all zero whenever `mem_en` is low.
- R6: A load that raises an alignment exception produces no register write: `wb_en` stays low in the following cycle.
- R7: Lane selection is big-endian. `mem_be[3]` covers data bits 31:24, which hold byte offset 0. A byte at offset k enables `4'b1000 >> k`. A half at offset 0 enables 4'b1100 and at offset 2 enables 4'b0011. A word enables 4'b1111. `mem_we` is 1 for stores and 0 for loads.
- R8: Store data is replicated onto the lanes: a byte store drives `{4{wdata[7:0]}}`, a half store drives `{2{wdata[15:0]}}` and a word store drives `wdata` unchanged.
- R9: A signed load (`req_signed`=1) of a byte or a half sign-extends the selected bits to 32 bits.
- R10: An unsigned load (`req_signed`=0) of a byte or a half zero-extends the selected bits to 32 bits.
- R11: One cycle after a faulting request, `exc_valid` is 1 for one cycle and `exc_addr` holds the faulting EA. Otherwise `exc_valid` is 0.
- R12: A load whose destination index is 0 never asserts `wb_en`, so register 0 keeps reading zero.
- R13: One cycle after a legal load to a nonzero destination, `wb_en` is 1, `wb_idx` is the destination and `wb_data` is the extended value taken from `mem_rdata`. Stores never assert `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half, 10/11 word |
| req_signed | input | 1 | Sign-extend a load result |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Immediate displacement (signed) |
| req_wdata | input | 32 | Store data, right-aligned |
| req_dest | input | 5 | Load destination register index |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_addr | output | 30 | Word address (EA bits 31:2) |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read data, one cycle after `mem_en` |
| wb_en | output | 1 | Register file write enable |
| wb_idx | output | 5 | Register file write index |
| wb_data | output | 32 | Extended load result |
| exc_valid | output | 1 | Alignment exception |
| exc_addr | output | 32 | Faulting effective address |

## Verification
The bench targets each misaligned offset for words (1, 2 and 3) and for halves (1 and 3), and also a byte at offset 3. A design that checks only bit 0 for words, or that also checks bytes, would raise the wrong exception. Faulting stores are followed by a read of the same word. A design that let the byte enables through would leave corrupted bytes that the reference byte-array memory exposes. Byte and half loads use values with bit 7 or bit 15 set to separate sign extension from zero extension. Lane ordering is exercised at every offset, so a little-endian or off-by-one lane map reads back the wrong byte. A negative displacement and a load to register 0 catch a zero-extended immediate and an unsuppressed write to register 0.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WALT = 2'b11
   } acc_size_e;

   localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DISP_W = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] ea,
   output logic              misalign
);
   import lsu_pkg::*;

   localparam int unsigned EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;
   acc_size_e         sz;

   generate
      if (EXT_W == 0) begin : g_no_ext
         assign disp_ext = disp;
      end else begin : g_ext
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end
   endgenerate

   assign ea = base + disp_ext;
   assign sz = acc_size_e'(size);

   always_comb begin
      unique case (sz)
         SZ_BYTE: misalign = 1'b0;
         SZ_HALF: misalign = ea[0];
         default: misalign = |ea[1:0];
      endcase
   end
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
   parameter int unsigned DATA_W     = 32,
   parameter bit          BIG_ENDIAN = 1'b1
) (
   input  logic [1:0]          off,
   input  logic [1:0]          size,
   input  logic [DATA_W-1:0]   wdata_in,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   wdata_out
);
   import lsu_pkg::*;

   localparam int unsigned LANES = DATA_W / LANE_BITS;

   logic [1:0] byte_lane;
   logic       hi_pair;
   acc_size_e  sz;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign byte_lane = ~off;
         assign hi_pair   = ~off[1];
      end else begin : g_little
         assign byte_lane = off;
         assign hi_pair   = off[1];
      end
   endgenerate

   assign sz = acc_size_e'(size);

   always_comb begin
      unique case (sz)
         SZ_BYTE: begin
            be        = LANES'(1) << byte_lane;
            wdata_out = {4{wdata_in[7:0]}};
         end
         SZ_HALF: begin
            be        = hi_pair ? 4'b1100 : 4'b0011;
            wdata_out = {2{wdata_in[15:0]}};
         end
         default: begin
            be        = '1;
            wdata_out = wdata_in;
         end
      endcase
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
   parameter int unsigned DATA_W     = 32,
   parameter bit          BIG_ENDIAN = 1'b1
) (
   input  logic [DATA_W-1:0] rdata,
   input  logic [1:0]        off,
   input  logic [1:0]        size,
   input  logic              sgn,
   output logic [DATA_W-1:0] result
);
   import lsu_pkg::*;

   logic [1:0]  byte_lane;
   logic        hi_pair;
   logic [7:0]  b_val;
   logic [15:0] h_val;
   acc_size_e   sz;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign byte_lane = ~off;
         assign hi_pair   = ~off[1];
      end else begin : g_little
         assign byte_lane = off;
         assign hi_pair   = off[1];
      end
   endgenerate

   assign sz    = acc_size_e'(size);
   assign b_val = rdata[LANE_BITS*byte_lane +: LANE_BITS];
   assign h_val = hi_pair ? rdata[31:16] : rdata[15:0];

   always_comb begin
      unique case (sz)
         SZ_BYTE: result = {{24{sgn & b_val[7]}}, b_val};
         SZ_HALF: result = {{16{sgn & h_val[15]}}, h_val};
         default: result = rdata;
      endcase
   end
endmodule

// File: rtl/lsu_align_ext.sv
module lsu_align_ext #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DISP_W     = 16,
   parameter int unsigned REG_IDX_W  = 5,
   parameter bit          BIG_ENDIAN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_store,
   input  logic [1:0]            req_size,
   input  logic                  req_signed,
   input  logic [ADDR_W-1:0]     req_base,
   input  logic [DISP_W-1:0]     req_disp,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [REG_IDX_W-1:0]  req_dest,
   output logic                  mem_en,
   output logic                  mem_we,
   output logic [DATA_W/8-1:0]   mem_be,
   output logic [ADDR_W-3:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   input  logic [DATA_W-1:0]     mem_rdata,
   output logic                  wb_en,
   output logic [REG_IDX_W-1:0]  wb_idx,
   output logic [DATA_W-1:0]     wb_data,
   output logic                  exc_valid,
   output logic [ADDR_W-1:0]     exc_addr
);
   localparam int unsigned LANES = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("lsu_align_ext: DATA_W must be 32");
   end
   if (DISP_W > ADDR_W) begin : g_bad_disp_w
      $error("lsu_align_ext: DISP_W must not exceed ADDR_W");
   end
   if (REG_IDX_W < 1) begin : g_bad_idx_w
      $error("lsu_align_ext: REG_IDX_W must be at least 1");
   end

   logic [ADDR_W-1:0] ea;
   logic              misalign;
   logic [LANES-1:0]  be_raw;
   logic [DATA_W-1:0] wdata_rep;
   logic              access_ok;

   lsu_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
      .base     (req_base),
      .disp     (req_disp),
      .size     (req_size),
      .ea       (ea),
      .misalign (misalign)
   );

   lsu_lane_steer #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_steer (
      .off       (ea[1:0]),
      .size      (req_size),
      .wdata_in  (req_wdata),
      .be        (be_raw),
      .wdata_out (wdata_rep)
   );

   assign access_ok = req_valid & ~misalign;
   assign mem_en    = access_ok;
   assign mem_we    = access_ok & req_store;
   assign mem_be    = access_ok ? be_raw : '0;
   assign mem_addr  = ea[ADDR_W-1:2];
   assign mem_wdata = wdata_rep;

   // Write-back stage state: one cycle behind the request.
   logic                 ld_pend_q;
   logic [REG_IDX_W-1:0] ld_idx_q;
   logic [1:0]           ld_off_q;
   logic [1:0]           ld_size_q;
   logic                 ld_sgn_q;
   logic                 exc_q;
   logic [ADDR_W-1:0]    exc_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_pend_q  <= 1'b0;
         ld_idx_q   <= '0;
         ld_off_q   <= '0;
         ld_size_q  <= '0;
         ld_sgn_q   <= 1'b0;
         exc_q      <= 1'b0;
         exc_addr_q <= '0;
      end else begin
         ld_pend_q <= access_ok & ~req_store;
         exc_q     <= req_valid & misalign;
         if (access_ok & ~req_store) begin
            ld_idx_q  <= req_dest;
            ld_off_q  <= ea[1:0];
            ld_size_q <= req_size;
            ld_sgn_q  <= req_signed;
         end
         if (req_valid & misalign) begin
            exc_addr_q <= ea;
         end
      end
   end

   lsu_load_extract #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_extract (
      .rdata  (mem_rdata),
      .off    (ld_off_q),
      .size   (ld_size_q),
      .sgn    (ld_sgn_q),
      .result (wb_data)
   );

   assign wb_en     = ld_pend_q & (ld_idx_q != '0);
   assign wb_idx    = ld_idx_q;
   assign exc_valid = exc_q;
   assign exc_addr  = exc_addr_q;
endmodule

// File: rtl/lsu_align_ext_chk.sv
module lsu_align_ext_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LANES     = 4,
   parameter int unsigned REG_IDX_W = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [1:0]           req_size,
   input logic                 mem_en,
   input logic [LANES-1:0]     mem_be,
   input logic                 wb_en,
   input logic [REG_IDX_W-1:0] wb_idx,
   input logic                 exc_valid,
   input logic [ADDR_W-1:0]    exc_addr
);
   // R5: the cycle before an exception carried no access and no byte enable
   a_r5_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> $past(!mem_en && mem_be == '0));

   // R5: byte enables stay quiet whenever no access is made
   a_r5_idle_no_be: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en |-> mem_be == '0);

   // R6: a faulting load never writes the register file
   a_r6_no_wb_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !wb_en);

   // R12: register 0 is never written
   a_r12_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wb_idx != '0);

   // R4: a byte request never produces an exception
   a_r4_byte_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'b00) |=> !exc_valid);

   // R11: a reported faulting address is never word-aligned
   a_r11_fault_addr_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> exc_addr[1:0] != 2'b00);

   // R7: an access always enables one byte, an aligned pair or the whole word
   a_r7_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 ||
                  mem_be == 4'b0011 || mem_be == 4'b1111));
endmodule

bind lsu_align_ext lsu_align_ext_chk #(
   .ADDR_W    (ADDR_W),
   .LANES     (DATA_W/8),
   .REG_IDX_W (REG_IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_size  (req_size),
   .mem_en    (mem_en),
   .mem_be    (mem_be),
   .wb_en     (wb_en),
   .wb_idx    (wb_idx),
   .exc_valid (exc_valid),
   .exc_addr  (exc_addr)
);

// File: tb/tb_lsu_align_ext.sv
`timescale 1ns/1ps
module tb_lsu_align_ext;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
   logic [1:0]  req_size = 2'b00;
   logic [31:0] req_base = '0, req_wdata = '0;
   logic [15:0] req_disp = '0;
   logic [4:0]  req_dest = '0;
   logic        mem_en, mem_we, wb_en, exc_valid;
   logic [3:0]  mem_be;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata, wb_data, exc_addr;
   logic [4:0]  wb_idx;

   always #2.5 clk = ~clk;

   lsu_align_ext dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
      .req_disp(req_disp), .req_wdata(req_wdata), .req_dest(req_dest),
      .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wb_en(wb_en),
      .wb_idx(wb_idx), .wb_data(wb_data), .exc_valid(exc_valid),
      .exc_addr(exc_addr)
   );

   // Environment memory: 16 words driven by the design's port.
   logic [31:0] ram [16];
   always_ff @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            for (int i = 0; i < 4; i++)
               if (mem_be[i]) ram[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
         end else begin
            mem_rdata <= ram[mem_addr[3:0]];
         end
      end
   end

   // Reference model: byte array, offset 0 of each word is its first byte.
   logic [7:0] refmem [64];

   int n_chk = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;

   logic        exp_wb_en = 1'b0, exp_exc = 1'b0;
   logic [4:0]  exp_wb_idx = '0;
   logic [31:0] exp_wb_data = '0, exp_exc_addr = '0;

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         summary();
         $finish;
      end
   end

   function automatic logic [31:0] load_val(logic [31:0] ea, logic [1:0] sz, logic sg);
      logic [5:0] a = ea[5:0];
      logic [7:0] b;
      logic [15:0] h;
      if (sz == 2'b00) begin
         b = refmem[a];
         return sg ? {{24{b[7]}}, b} : {24'h0, b};
      end else if (sz == 2'b01) begin
         h = {refmem[a], refmem[a+6'd1]};
         return sg ? {{16{h[15]}}, h} : {16'h0, h};
      end
      return {refmem[a], refmem[a+6'd1], refmem[a+6'd2], refmem[a+6'd3]};
   endfunction

   task automatic step(bit v, bit st, logic [1:0] sz, bit sg, logic [31:0] base,
                       logic [15:0] disp, logic [31:0] wd, logic [4:0] dst, string tag);
      logic [31:0] ea;
      bit          fault;
      logic [3:0]  ebe;
      logic [31:0] ewd;
      @(negedge clk);
      // Results of the previous request (registered stage).
      check({tag, " R13 wb_en (prev)"}, 32'(wb_en), 32'(exp_wb_en));
      if (exp_wb_en) begin
         check({tag, " R13 wb_idx (prev)"}, 32'(wb_idx), 32'(exp_wb_idx));
         check({tag, " R9/R10 wb_data (prev)"}, wb_data, exp_wb_data);
      end
      check({tag, " R11 exc_valid (prev)"}, 32'(exc_valid), 32'(exp_exc));
      if (exp_exc) check({tag, " R11 exc_addr (prev)"}, exc_addr, exp_exc_addr);
      // Drive the new request.
      req_valid = v; req_store = st; req_size = sz; req_signed = sg;
      req_base = base; req_disp = disp; req_wdata = wd; req_dest = dst;
      #1;
      ea = base + {{16{disp[15]}}, disp};
      case (sz)
         2'b00: fault = 1'b0;
         2'b01: fault = ea[0];
         default: fault = (ea[1:0] != 2'b00);
      endcase
      case (sz)
         2'b00: begin ebe = 4'b1000 >> ea[1:0]; ewd = {4{wd[7:0]}}; end
         2'b01: begin ebe = ea[1] ? 4'b0011 : 4'b1100; ewd = {2{wd[15:0]}}; end
         default: begin ebe = 4'b1111; ewd = wd; end
      endcase
      check({tag, " R2/R3/R4 mem_en"}, 32'(mem_en), 32'(v && !fault));
      if (v && !fault) begin
         check({tag, " R1 mem_addr"}, 32'(mem_addr), {2'b00, ea[31:2]});
         check({tag, " R7 mem_we"}, 32'(mem_we), 32'(st));
         check({tag, " R7 mem_be"}, 32'(mem_be), 32'(ebe));
         if (st) check({tag, " R8 mem_wdata"}, mem_wdata, ewd);
      end else begin
         check({tag, " R5 mem_be idle"}, 32'(mem_be), 32'h0);
      end
      exp_wb_en    = v && !st && !fault && (dst != 5'd0);
      exp_wb_idx   = dst;
      exp_wb_data  = load_val(ea, sz, sg);
      exp_exc      = v && fault;
      exp_exc_addr = ea;
      if (v && st && !fault) begin
         if (sz == 2'b00) refmem[ea[5:0]] = wd[7:0];
         else if (sz == 2'b01) begin
            refmem[ea[5:0]] = wd[15:8]; refmem[ea[5:0]+6'd1] = wd[7:0];
         end else begin
            refmem[ea[5:0]]      = wd[31:24]; refmem[ea[5:0]+6'd1] = wd[23:16];
            refmem[ea[5:0]+6'd2] = wd[15:8];  refmem[ea[5:0]+6'd3] = wd[7:0];
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) refmem[i] = 8'((i*37 + 133) & 255);
      for (int w = 0; w < 16; w++)
         ram[w] = {refmem[4*w], refmem[4*w+1], refmem[4*w+2], refmem[4*w+3]};
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      check("reset wb_en", 32'(wb_en), 32'h0);
      check("reset R11 exc_valid", 32'(exc_valid), 32'h0);
      check("reset R5 mem_en", 32'(mem_en), 32'h0);
      rst_n = 1'b1;

      step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 5'd0, "idle");
      // R1: negative displacement, EA = 0x1000 - 0x1000 = 0
      step(1, 1, 2'b10, 0, 32'h1000, 16'hF000, 32'h11223344, 5'd0, "R1 word store");
      step(1, 1, 2'b00, 0, 32'h4, 16'h0001, 32'h000000A5, 5'd0, "R8 byte store off1");
      step(1, 1, 2'b01, 0, 32'h8, 16'h0002, 32'h00009ABC, 5'd0, "R8 half store off2");
      step(1, 1, 2'b01, 0, 32'h20, 16'h0000, 32'h00001234, 5'd0, "R7 half store off0");
      step(1, 1, 2'b00, 0, 32'h30, 16'h0003, 32'h0000005A, 5'd0, "R7 byte store off3");
      step(1, 0, 2'b10, 0, 32'h1000, 16'hF000, 32'h0, 5'd3, "R13 word load");
      step(1, 0, 2'b00, 1, 32'h4, 16'h0001, 32'h0, 5'd4, "R9 signed byte");
      step(1, 0, 2'b00, 0, 32'h4, 16'h0001, 32'h0, 5'd4, "R10 unsigned byte");
      step(1, 0, 2'b01, 1, 32'h8, 16'h0002, 32'h0, 5'd6, "R9 signed half");
      step(1, 0, 2'b01, 0, 32'h8, 16'h0002, 32'h0, 5'd6, "R10 unsigned half");
      step(1, 0, 2'b01, 1, 32'h20, 16'h0000, 32'h0, 5'd7, "R9 half off0");
      step(1, 0, 2'b10, 0, 32'h30, 16'h0000, 32'h0, 5'd8, "R7 word after byte off3");
      for (int k = 0; k < 4; k++) begin
         step(1, 0, 2'b00, 1, 32'h14, 16'(k), 32'h0, 5'd9, "R4 byte load each offset");
         step(1, 0, 2'b00, 0, 32'h18, 16'(k), 32'h0, 5'd9, "R4 R10 byte load each offset");
      end
      step(1, 0, 2'b10, 0, 32'h10, 16'h0001, 32'h0, 5'd5, "R2 R6 word off1");
      step(1, 0, 2'b10, 0, 32'h10, 16'h0002, 32'h0, 5'd5, "R2 R6 word off2");
      step(1, 0, 2'b10, 0, 32'h10, 16'h0003, 32'h0, 5'd5, "R2 R6 word off3");
      step(1, 0, 2'b11, 0, 32'h10, 16'h0002, 32'h0, 5'd5, "R2 spare size off2");
      step(1, 0, 2'b11, 1, 32'h10, 16'h0000, 32'h0, 5'd5, "R2 spare size aligned");
      step(1, 0, 2'b01, 1, 32'h10, 16'h0001, 32'h0, 5'd5, "R3 R6 half off1");
      step(1, 0, 2'b01, 1, 32'h10, 16'h0003, 32'h0, 5'd5, "R3 R6 half off3");
      step(1, 1, 2'b10, 0, 32'h4, 16'h0002, 32'hDEADBEEF, 5'd0, "R5 faulting word store");
      step(1, 1, 2'b01, 0, 32'h4, 16'h0003, 32'h0000CAFE, 5'd0, "R5 faulting half store");
      step(1, 0, 2'b10, 0, 32'h4, 16'h0000, 32'h0, 5'd10, "R5 readback after fault");
      step(1, 0, 2'b10, 0, 32'h1000, 16'hF000, 32'h0, 5'd0, "R12 load to r0");
      step(1, 0, 2'b00, 1, 32'h4, 16'h0001, 32'h0, 5'd0, "R12 byte load to r0");
      step(1, 0, 2'b10, 0, 32'h2000, 16'hFFFF, 32'h0, 5'd11, "R11 fault addr neg disp");
      step(1, 1, 2'b10, 0, 32'h2000, 16'h7FFE, 32'h0, 5'd0, "R11 store fault addr");
      step(1, 0, 2'b01, 0, 32'h3C, 16'h0002, 32'h0, 5'd12, "R13 half off2 after fault");
      step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 5'd0, "flush");
      step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 5'd0, "idle end");
      done = 1'b1;
      summary();
      $finish;
   end
endmodule